// File: doc/BRIEF.md
# Fractional-Step PWM Channel with Shadowed Settings

This block drives one pulse-width-modulated output from a phase accumulator. On every enabled clock the accumulator adds a programmable step, the base unit. Its carry-out marks the start of a new output cycle. The eight most significant accumulator bits give the current position within the cycle. That position is compared with an 8-bit on-time divider to set the output level.

Software uses one 32-bit control word, written through a simple write strobe and read back combinationally. Writes to the base-unit and divider fields go into a staging copy. The staged values become the active setting only after software raises the update request bit. While the channel is enabled, the transfer happens at the next accumulator wrap. While it is disabled, the transfer happens on the next clock. The hardware clears the request bit when the transfer is done, so software polls the bit before it writes a new setting.

Top module: `accum_pwm`

## Requirements
- R1: After reset the output is low and the read word is all zeros.
- R2: The read word holds the enable bit at bit 31 and the pending-update bit at bit 30. It holds the staged base unit at bits [8 +: STEP_W] and the staged divider at bits [7:0]. All other bits read zero.
- R3: Writing a 1 to bit 30 sets the update request, and writing 0 there never clears it. While the channel is disabled, a pending request copies the staged values to the active copy on the next clock and clears itself.
- R4: While the channel is enabled, a pending request takes effect only at the accumulator wrap. The bit stays set until then, and the output keeps following the old setting until then.
- R5: While the update bit is set, writes leave the staged base unit and divider unchanged. The enable bit is still written.
- R6: With an active base unit B, the accumulator adds B every enabled clock, so one output period lasts 2^STEP_W / B clocks. With STEP_W = 16, B = 0x100 gives 256 clocks and B = 0x200 gives 128 clocks.
- R7: The output is high while the accumulator's top eight bits are greater than or equal to the active divider D. A full period at B = 0x100 therefore holds 256 − D high clocks: D = 0 is always high and D = 255 gives one high clock.
- R8: Writing enable = 0 drives the output low from the next clock and clears the accumulator. After the next enable, the first D clocks are low, counted from the clock on which the enable write lands.
- R9: An active base unit of zero stops the accumulator. No wrap occurs, the output stays constant, and a request made while enabled stays pending until the channel is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control-word write strobe |
| wr_data_i | input | 32 | Control word to write |
| rd_data_o | output | 32 | Control word read back (staged fields, live enable and update bits) |
| pwm_o | output | 1 | PWM output |

## Verification
The bench makes update requests immediately after a rising output edge, which is mid-cycle. It checks that the request bit stays set and the old duty stays in force until the wrap. A design that applies the setting at once would show a broken cycle, and would clear the bit too early. It then writes new fields while a request is pending. A design without the lock would let the final duty follow the second write. The bench also covers the divider extremes 0 and 255, and a restart after disable that must begin at position zero. With a zero base unit it checks that the accumulator stands still and the request stays pending, where a faulty design would apply the setting or glitch the output.

// File: rtl/accum_pwm_pkg.sv
package accum_pwm_pkg;
  localparam int unsigned CTRL_W   = 32;
  localparam int unsigned EN_BIT   = 31;
  localparam int unsigned UPD_BIT  = 30;
  localparam int unsigned STEP_LSB = 8;
  localparam int unsigned DIV_W    = 8;

  typedef logic [DIV_W-1:0] div_t;
endpackage

// File: rtl/accum_pwm_regs.sv
module accum_pwm_regs
  import accum_pwm_pkg::*;
#(
  parameter int unsigned STEP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              apply_i,
  output logic              en_o,
  output logic              upd_o,
  output logic [STEP_W-1:0] stg_step_o,
  output div_t              stg_div_o,
  output logic [STEP_W-1:0] act_step_o,
  output div_t              act_div_o
);
  logic              en_q, upd_q;
  logic [STEP_W-1:0] stg_step_q, act_step_q;
  div_t              stg_div_q, act_div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      upd_q      <= 1'b0;
      stg_step_q <= '0;
      stg_div_q  <= '0;
      act_step_q <= '0;
      act_div_q  <= '0;
    end else begin
      if (wr_en_i) en_q <= wr_data_i[EN_BIT];
      // request clears only through an apply; a write of 0 has no effect
      if (apply_i) begin
        act_step_q <= stg_step_q;
        act_div_q  <= stg_div_q;
        upd_q      <= 1'b0;
      end else if (wr_en_i && wr_data_i[UPD_BIT]) begin
        upd_q <= 1'b1;
      end
      // staged fields are locked while a request is pending
      if (wr_en_i && !upd_q) begin
        stg_step_q <= wr_data_i[STEP_LSB +: STEP_W];
        stg_div_q  <= wr_data_i[DIV_W-1:0];
      end
    end
  end

  assign en_o       = en_q;
  assign upd_o      = upd_q;
  assign stg_step_o = stg_step_q;
  assign stg_div_o  = stg_div_q;
  assign act_step_o = act_step_q;
  assign act_div_o  = act_div_q;
endmodule

// File: rtl/accum_pwm_phase.sv
module accum_pwm_phase #(
  parameter int unsigned STEP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [STEP_W-1:0] acc_o,
  output logic              wrap_o
);
  logic [STEP_W-1:0] acc_q;
  logic [STEP_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, step_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (!en_i)  acc_q <= '0;
    else             acc_q <= sum[STEP_W-1:0];
  end

  assign acc_o  = acc_q;
  assign wrap_o = en_i & sum[STEP_W];
endmodule

// File: rtl/accum_pwm_cmp.sv
module accum_pwm_cmp
  import accum_pwm_pkg::*;
(
  input  logic en_i,
  input  div_t pos_i,
  input  div_t div_i,
  output logic pwm_o
);
  assign pwm_o = en_i & (pos_i >= div_i);
endmodule

// File: rtl/accum_pwm.sv
module accum_pwm
  import accum_pwm_pkg::*;
#(
  parameter int unsigned STEP_W = 16  // 8..22
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        pwm_o
);
  localparam int unsigned POS_MSB = STEP_W - 1;

  logic              ctl_en, ctl_upd, wrap, apply;
  logic [STEP_W-1:0] stg_step, act_step, acc_val;
  div_t              stg_div, act_div, pos;

  // no cycle runs while disabled, so a pending request applies right away
  assign apply = ctl_upd & (~ctl_en | wrap);

  accum_pwm_regs #(.STEP_W(STEP_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .apply_i    (apply),
    .en_o       (ctl_en),
    .upd_o      (ctl_upd),
    .stg_step_o (stg_step),
    .stg_div_o  (stg_div),
    .act_step_o (act_step),
    .act_div_o  (act_div)
  );

  accum_pwm_phase #(.STEP_W(STEP_W)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctl_en),
    .step_i (act_step),
    .acc_o  (acc_val),
    .wrap_o (wrap)
  );

  assign pos = acc_val[POS_MSB -: DIV_W];

  accum_pwm_cmp u_cmp (
    .en_i  (ctl_en),
    .pos_i (pos),
    .div_i (act_div),
    .pwm_o (pwm_o)
  );

  always_comb begin
    rd_data_o                      = '0;
    rd_data_o[EN_BIT]              = ctl_en;
    rd_data_o[UPD_BIT]             = ctl_upd;
    rd_data_o[STEP_LSB +: STEP_W]  = stg_step;
    rd_data_o[DIV_W-1:0]           = stg_div;
  end
endmodule

// File: rtl/accum_pwm_checker.sv
module accum_pwm_checker #(
  parameter int unsigned STEP_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [31:0]       rd_data_o,
  input logic              pwm_o,
  input logic              ctl_en,
  input logic              ctl_upd,
  input logic [STEP_W-1:0] acc_val,
  input logic [STEP_W-1:0] act_step
);
  assert_off_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[31] |-> !pwm_o);

  assert_acc_cleared_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_en |=> acc_val == '0);

  assert_fields_locked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_upd && wr_en_i) |=> $stable(rd_data_o[29:0]));

  assert_idle_apply_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_en && ctl_upd) |=> !ctl_upd);

  assert_stopped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_en && act_step == '0 && !wr_en_i) |=> ($stable(acc_val) && ctl_upd == $past(ctl_upd)));
endmodule

bind accum_pwm accum_pwm_checker #(.STEP_W(STEP_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .rd_data_o (rd_data_o),
  .pwm_o     (pwm_o),
  .ctl_en    (ctl_en),
  .ctl_upd   (ctl_upd),
  .acc_val   (acc_val),
  .act_step  (act_step)
);

// File: tb/accum_pwm_test.sv
module accum_pwm_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        pwm_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  accum_pwm uut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .pwm_o     (pwm_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [31:0] d);
    wr_en_i   = 1'b1;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i   = 1'b0;
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_o) hi++;
      @(negedge clk_i);
    end
  endtask

  task automatic wait_rise();
    logic prev;
    prev = pwm_o;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk_i);
      if (pwm_o && !prev) return;
      prev = pwm_o;
    end
  endtask

  task automatic wait_upd_clear(output int clks);
    clks = 0;
    while (rd_data_o[30] && clks < 1000) begin
      @(negedge clk_i);
      clks++;
    end
  endtask

  task automatic measure_period(output int p);
    logic prev;
    wait_rise();
    p = 0;
    prev = pwm_o;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk_i);
      p++;
      if (pwm_o && !prev) return;
      prev = pwm_o;
    end
  endtask

  task automatic t_reset();
    check(rd_data_o == 32'h0, "R1 read word", rd_data_o, 0);
    check(pwm_o == 1'b0, "R1 output", pwm_o, 0);
  endtask

  task automatic t_idle_update();
    write_reg(32'h0001_0080);
    check(rd_data_o == 32'h0001_0080, "R2 staged layout", rd_data_o, 32'h0001_0080);
    write_reg(32'h4001_0080);
    check(rd_data_o[30] == 1'b1, "R3 request set", rd_data_o[30], 1);
    @(negedge clk_i);
    check(rd_data_o[30] == 1'b0, "R3 idle self-clear", rd_data_o[30], 0);
    write_reg(32'h0001_0080);
    check(rd_data_o[30] == 1'b0, "R3 write zero keeps clear", rd_data_o[30], 0);
  endtask

  task automatic t_enable_duty();
    int hi;
    write_reg(32'h8001_0080);
    check(rd_data_o == 32'h8001_0080, "R2 enable bit", rd_data_o, 32'h8001_0080);
    count_high(256, hi);
    check(hi == 128, "R7 duty div 0x80", hi, 128);
  endtask

  task automatic t_frequency();
    int p, c;
    write_reg(32'hC002_0080);
    wait_upd_clear(c);
    measure_period(p);
    check(p == 128, "R6 period step 0x200", p, 128);
    write_reg(32'hC001_0080);
    wait_upd_clear(c);
    measure_period(p);
    check(p == 256, "R6 period step 0x100", p, 256);
  endtask

  task automatic t_div_extremes();
    int hi, c;
    write_reg(32'hC001_0000);
    wait_upd_clear(c);
    count_high(256, hi);
    check(hi == 256, "R7 div 0 always high", hi, 256);
    write_reg(32'hC001_00FF);
    wait_upd_clear(c);
    count_high(256, hi);
    check(hi == 1, "R7 div 255 one high", hi, 1);
    write_reg(32'hC001_0080);
    wait_upd_clear(c);
  endtask

  task automatic t_boundary_update();
    int hi, c;
    wait_rise();
    write_reg(32'hC001_0040);
    check(rd_data_o[30] == 1'b1, "R4 request pending mid-cycle", rd_data_o[30], 1);
    repeat (60) @(negedge clk_i);
    check(rd_data_o[30] == 1'b1, "R4 still pending before wrap", rd_data_o[30], 1);
    check(pwm_o == 1'b1, "R4 old duty kept", pwm_o, 1);
    wait_upd_clear(c);
    check(c > 40 && c < 80, "R4 clears at wrap", c, 66);
    count_high(256, hi);
    check(hi == 192, "R4 new duty active", hi, 192);
  endtask

  task automatic t_locked_fields();
    int hi, c;
    wait_rise();
    write_reg(32'hC001_0020);
    write_reg(32'h8001_0010);
    check(rd_data_o[7:0] == 8'h20, "R5 divider locked", rd_data_o[7:0], 8'h20);
    wait_upd_clear(c);
    count_high(256, hi);
    check(hi == 224, "R5 pending value used", hi, 224);
  endtask

  task automatic t_disable_restart();
    int lows;
    write_reg(32'hC001_0040);
    write_reg(32'h0001_0040);
    check(pwm_o == 1'b0, "R8 low after disable", pwm_o, 0);
    check(rd_data_o[31] == 1'b0, "R8 enable reads 0", rd_data_o[31], 0);
    @(negedge clk_i);
    write_reg(32'h8001_0040);
    lows = 0;
    while (!pwm_o && lows < 1000) begin
      lows++;
      @(negedge clk_i);
    end
    check(lows == 64, "R8 restart from zero", lows, 64);
  endtask

  task automatic t_zero_step();
    int hi, c;
    write_reg(32'h0000_0080);
    write_reg(32'h4000_0080);
    @(negedge clk_i);
    write_reg(32'h8000_0080);
    count_high(300, hi);
    check(hi == 0, "R9 stopped output low", hi, 0);
    write_reg(32'hC001_0080);
    repeat (300) @(negedge clk_i);
    check(rd_data_o[30] == 1'b1, "R9 request stays pending", rd_data_o[30], 1);
    write_reg(32'h0001_0080);
    wait_upd_clear(c);
    check(c <= 1, "R9 disable releases request", c, 1);
  endtask

  initial begin
    #(20 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_idle_update();
    t_enable_duty();
    t_frequency();
    t_div_extremes();
    t_boundary_update();
    t_locked_fields();
    t_disable_restart();
    t_zero_step();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule